// File: doc/BRIEF.md
# Dual-Endian Load/Store Lane Aligner

This block sits between a 32-bit register datapath and a byte-addressed, 32-bit-wide data memory port. For a store it moves the byte, halfword or word operand onto the byte lanes the address selects and raises the matching byte enables. For a load it picks the addressed bytes out of the returned memory word and widens them to 32 bits, with sign or zero fill. A mode pin chooses, at run time, whether the lowest address inside a word maps to the least significant byte (little-endian) or to the most significant byte (big-endian).

Every request is checked for natural alignment. An access whose address is not a whole multiple of its size, or one that uses the reserved size code, never reaches memory. Instead the block reports it with a one-cycle error pulse. Accesses are never split across several bus cycles.

Requests enter through a valid/ready pair. An aligned request is offered to memory in the same cycle, and it stalls exactly as long as memory holds off its ready. A misaligned request is consumed at once. Memory returns load data in the cycle after it accepts a read. The widened result is registered and announced by a one-cycle response strobe.

Top module: `lsu_lane_aligner`

## Requirements
- R1: The size code is 2'b00 byte, 2'b01 halfword, 2'b10 word. A byte access is aligned at any address. A halfword access is aligned when address bit 0 is 0. A word access is aligned when address bits 1:0 are 00. Size 2'b11 is always misaligned.
- R2: A misaligned request is accepted whatever the state of `mem_ready`. It drives `mem_valid` low and `mem_be` to 4'b0000, so memory is left untouched. It raises `misalign_err` for exactly the one cycle after acceptance. It produces no `rsp_valid` and leaves `ld_data` unchanged.
- R3: In little-endian mode (`big_endian`=0), the store byte at address offset o goes to physical lane o, and operand bit 0 sits at the lowest address. Lane k is `mem_wdata[8k+7:8k]` and `mem_be[k]`. Lanes that are not written carry zero data.
- R4: In big-endian mode, the byte at address offset o goes to lane 3-o, and the most significant operand byte sits at the lowest address. A halfword at offset 0 enables lanes 3 and 2 (4'b1100). A halfword at offset 2 enables lanes 1 and 0 (4'b0011).
- R5: In little-endian mode, a load assembles its result from lanes o, o+1, … with lane o as the least significant result byte.
- R6: In big-endian mode, a load takes the byte at the lowest address, which is lane 3-o, as the most significant result byte.
- R7: Byte and halfword loads are sign-extended when `req_signed` is 1 and zero-extended when it is 0. Word loads are returned unchanged.
- R8: For an aligned request, `mem_valid` follows `req_valid` and `req_ready` follows `mem_ready`. The request must be held while `req_ready` is low. `mem_addr` is the request address with bits 1:0 cleared.
- R9: An aligned load accepted at clock edge k takes `mem_rdata` during the following cycle. `rsp_valid` is high for one cycle after edge k+1, with the result on `ld_data`. `ld_data` changes only together with `rsp_valid`, and stores produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | 1 selects big-endian byte numbering |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 store, 0 load |
| req_size | input | 2 | Access size code |
| req_signed | input | 1 | Sign-extend narrow loads |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store operand, right-justified |
| mem_valid | output | 1 | Memory access offered |
| mem_ready | input | 1 | Memory accepts access |
| mem_write | output | 1 | Memory write |
| mem_addr | output | 32 | Word address, bits 1:0 zero |
| mem_be | output | 4 | Byte enables by physical lane |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Read word, valid the cycle after a read is accepted |
| rsp_valid | output | 1 | Load result strobe |
| ld_data | output | 32 | Extended load result |
| misalign_err | output | 1 | One-cycle misalignment pulse |

## Verification
A load's response and the error pulse of the request issued right after it can fall in the same cycle. The bench provokes this by accepting an aligned load and, on the very next edge, a misaligned load. Both `rsp_valid` and `misalign_err` are then high together. The load's value must still arrive on `ld_data`, and the rejected load must not disturb it afterwards. A scoreboard queue matches each response to its request. A per-cycle expectation flag judges the error pulse independently.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // context carried from request to load response
  typedef struct packed {
    logic [1:0] base;
    acc_size_e  size;
    logic       sext;
  } ld_ctx_t;
endpackage

// File: rtl/lsu_align_decode.sv
module lsu_align_decode
  import lsu_align_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFS_W = $clog2(LANES)
) (
  input  acc_size_e        size,
  input  logic [OFS_W-1:0] ofs,
  input  logic             big_endian,
  output logic             aligned,
  output logic [OFS_W-1:0] base,
  output logic [LANES-1:0] lane_mask
);
  logic [OFS_W:0] span;

  always_comb begin
    unique case (size)
      SZ_BYTE: begin aligned = 1'b1;                     span = (OFS_W+1)'(1); end
      SZ_HALF: begin aligned = ~ofs[0];                  span = (OFS_W+1)'(2); end
      SZ_WORD: begin aligned = (ofs == '0);              span = (OFS_W+1)'(LANES); end
      default: begin aligned = 1'b0;                     span = '0; end
    endcase
  end

  // big-endian placement mirrors the offset inside the word
  assign base = big_endian ? (OFS_W'(0) - span[OFS_W-1:0] - ofs) : ofs;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      lane_mask[l] = (l >= int'(base)) && (l < int'(base) + int'(span));
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer #(
  parameter int LANES = 4,
  localparam int DW    = 8 * LANES,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [DW-1:0]    wdata,
  input  logic [OFS_W-1:0] base,
  input  logic [LANES-1:0] lane_mask,
  input  logic             enable,
  output logic [LANES-1:0] be,
  output logic [DW-1:0]    lane_data
);
  logic [DW-1:0] shifted;

  assign shifted = wdata << {base, 3'b000};
  assign be      = enable ? lane_mask : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_data[8*g +: 8] = lane_mask[g] ? shifted[8*g +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DW = 8 * LANES
) (
  input  logic [DW-1:0] rdata,
  input  ld_ctx_t       ctx,
  output logic [DW-1:0] result
);
  logic [DW-1:0] shifted;

  assign shifted = rdata >> {ctx.base, 3'b000};

  always_comb begin
    unique case (ctx.size)
      SZ_BYTE: result = {{(DW-8){ctx.sext & shifted[7]}}, shifted[7:0]};
      SZ_HALF: result = {{(DW-16){ctx.sext & shifted[15]}}, shifted[15:0]};
      default: result = shifted;
    endcase
  end
endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  localparam int DW    = 8 * LANES,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     ld_data,
  output logic              misalign_err
);
  acc_size_e        size_e;
  logic             acc_ok;
  logic [OFS_W-1:0] base;
  logic [LANES-1:0] lane_mask;
  logic             fire;
  logic             pend_vld;
  ld_ctx_t          pend_ctx;
  logic [DW-1:0]    ld_next;

  assign size_e = acc_size_e'(req_size);

  lsu_align_decode #(.LANES(LANES)) u_dec (
    .size      (size_e),
    .ofs       (req_addr[OFS_W-1:0]),
    .big_endian(big_endian),
    .aligned   (acc_ok),
    .base      (base),
    .lane_mask (lane_mask)
  );

  assign mem_valid = req_valid & acc_ok;
  assign req_ready = acc_ok ? mem_ready : 1'b1;
  assign mem_write = req_write;
  assign mem_addr  = {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign fire      = req_valid & req_ready;

  lsu_store_steer #(.LANES(LANES)) u_st (
    .wdata    (req_wdata),
    .base     (base),
    .lane_mask(lane_mask),
    .enable   (mem_valid),
    .be       (mem_be),
    .lane_data(mem_wdata)
  );

  lsu_load_extract #(.LANES(LANES)) u_ld (
    .rdata (mem_rdata),
    .ctx   (pend_ctx),
    .result(ld_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      misalign_err <= 1'b0;
      pend_vld     <= 1'b0;
      pend_ctx     <= '0;
      rsp_valid    <= 1'b0;
      ld_data      <= '0;
    end else begin
      misalign_err <= fire & ~acc_ok;
      pend_vld     <= fire & acc_ok & ~req_write;
      if (fire & acc_ok & ~req_write)
        pend_ctx <= '{base: base, size: size_e, sext: req_signed};
      rsp_valid <= pend_vld;
      if (pend_vld) ld_data <= ld_next;
    end
  end
endmodule

// File: rtl/lsu_lane_aligner_chk.sv
module lsu_lane_aligner_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_size,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_write,
  input logic [1:0]  mem_addr_lo,
  input logic [3:0]  mem_be,
  input logic        rsp_valid,
  input logic [31:0] ld_data,
  input logic        misalign_err
);
  AST_RSVD_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'b11 |-> !mem_valid && mem_be == 4'b0000); // R2
  AST_ERR_AFTER_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_size == 2'b11 |=> misalign_err); // R2
  AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !misalign_err); // R2
  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr_lo == 2'b00); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |-> !req_ready); // R8
  AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                                || $countones(mem_be) == 4)); // R3
  AST_RSP_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_valid && mem_ready && !mem_write, 2)); // R9
  AST_LD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(ld_data)); // R9
endmodule

bind lsu_lane_aligner lsu_lane_aligner_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_size    (req_size),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .mem_write   (mem_write),
  .mem_addr_lo (mem_addr[1:0]),
  .mem_be      (mem_be),
  .rsp_valid   (rsp_valid),
  .ld_data     (ld_data),
  .misalign_err(misalign_err)
);

// File: tb/lsu_lane_aligner_tb_top.sv
module lsu_lane_aligner_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic big_endian = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
  logic [1:0] req_size = 2'b00;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic mem_ready = 1'b1;
  logic req_ready, mem_valid, mem_write, rsp_valid, misalign_err;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0] mem_be;
  logic [31:0] rd_word = '0;
  logic [31:0] memarr [16];

  int checks = 0, errors = 0;
  bit done = 0;
  bit exp_err = 0;
  logic [31:0] rsp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  lsu_lane_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .req_wdata(req_wdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(rd_word), .rsp_valid(rsp_valid),
    .ld_data(ld_data), .misalign_err(misalign_err));

  // memory model keyed by physical lanes
  initial for (int i = 0; i < 16; i++) memarr[i] = '0;
  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_write) begin
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) memarr[mem_addr[5:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
      end else rd_word <= memarr[mem_addr[5:2]];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: response scoreboard and error pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (rsp_q.size() == 0) chk(0, "R9 unexpected response", ld_data, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = rsp_q.pop_front();
          t = tag_q.pop_front();
          chk(ld_data === e, t, ld_data, e);
        end
      end
      if (exp_err || misalign_err)
        chk(misalign_err === exp_err, "R2 error pulse", {31'b0, misalign_err}, {31'b0, exp_err});
      exp_err = 0;
    end
  end

  function automatic int nbytes(input logic [1:0] sz);
    return sz == 2'b00 ? 1 : (sz == 2'b01 ? 2 : 4);
  endfunction

  function automatic int lane_of(input int a);
    return big_endian ? 3 - a : a;
  endfunction

  task automatic do_req(input logic wr, input logic [1:0] sz, input logic sx,
                        input logic [31:0] ad, input logic [31:0] wd, input string tag);
    bit ok;
    int n, o;
    logic [3:0] ebe;
    logic [31:0] ewd, ev;
    ok = (sz == 2'b00) || (sz == 2'b01 && !ad[0]) || (sz == 2'b10 && ad[1:0] == 2'b00); // R1
    n = nbytes(sz);
    o = int'(ad[1:0]);
    req_valid = 1; req_write = wr; req_size = sz; req_signed = sx;
    req_addr = ad; req_wdata = wd;
    #1;
    if (!req_ready) chk(mem_valid === ok, "R8 stall offer", {31'b0, mem_valid}, {31'b0, ok});
    while (!req_ready) @(negedge clk);
    if (ok) begin
      chk(mem_valid === 1'b1 && mem_addr === {ad[31:2], 2'b00}, {tag, " R8 offer"}, mem_addr, {ad[31:2], 2'b00});
      ebe = '0; ewd = '0; ev = '0;
      for (int i = 0; i < n; i++) begin
        int ln, pos;
        ln = lane_of(o + i);
        pos = big_endian ? n - 1 - i : i;
        ebe[ln] = 1'b1;
        ewd[8*ln +: 8] = wd[8*pos +: 8];
        ev[8*pos +: 8] = memarr[ad[5:2]][8*ln +: 8];
      end
      if (wr) begin
        chk(mem_be === ebe, {tag, " be"}, {28'b0, mem_be}, {28'b0, ebe});
        chk(mem_wdata === ewd, {tag, " wdata"}, mem_wdata, ewd);
      end else begin
        if (n == 1) ev = {{24{sx & ev[7]}}, ev[7:0]};
        if (n == 2) ev = {{16{sx & ev[15]}}, ev[15:0]};
        rsp_q.push_back(ev);
        tag_q.push_back(tag);
      end
    end else begin
      chk(mem_valid === 1'b0 && mem_be === 4'b0, {tag, " R2 suppressed"}, {27'b0, mem_valid, mem_be}, 32'h0);
    end
    @(posedge clk);
    exp_err = !ok;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk(mem_valid === 0 && rsp_valid === 0 && misalign_err === 0 && ld_data === 0,
        "reset state", ld_data, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // little-endian stores and loads
    big_endian = 0;
    do_req(1, 2'b10, 0, 32'h00, 32'h8877_66F5, "R3 LE word store");
    do_req(1, 2'b00, 0, 32'h05, 32'h0000_00A1, "R3 LE byte store");
    do_req(1, 2'b01, 0, 32'h06, 32'h0000_C3B2, "R3 LE half store");
    do_req(0, 2'b10, 0, 32'h00, 0, "R5 LE word load");
    do_req(0, 2'b00, 1, 32'h00, 0, "R7 LE byte signed");
    do_req(0, 2'b00, 0, 32'h03, 0, "R7 LE byte unsigned");
    do_req(0, 2'b01, 1, 32'h06, 0, "R7 LE half signed");
    do_req(0, 2'b01, 0, 32'h02, 0, "R5 LE half unsigned");
    do_req(0, 2'b00, 1, 32'h05, 0, "R5 LE byte offset1");

    // big-endian
    big_endian = 1;
    do_req(1, 2'b01, 0, 32'h10, 32'h0000_9A7C, "R4 BE half offset0");
    do_req(1, 2'b01, 0, 32'h12, 32'h0000_1E2F, "R4 BE half offset2");
    do_req(1, 2'b00, 0, 32'h15, 32'h0000_00E4, "R4 BE byte offset1");
    do_req(1, 2'b10, 0, 32'h18, 32'hDEAD_BEEF, "R4 BE word store");
    do_req(0, 2'b10, 0, 32'h10, 0, "R6 BE word load");
    do_req(0, 2'b01, 1, 32'h10, 0, "R7 BE half signed");
    do_req(0, 2'b00, 0, 32'h19, 0, "R6 BE byte offset1");
    do_req(0, 2'b10, 0, 32'h00, 0, "R6 BE reads LE-written word");
    idle(3);

    // misalignment: memory untouched, load result held
    held = ld_data;
    do_req(1, 2'b01, 0, 32'h11, 32'h0000_5555, "R1 half odd store");
    do_req(1, 2'b10, 0, 32'h12, 32'h6666_6666, "R1 word offset2 store");
    do_req(0, 2'b11, 0, 32'h10, 0, "R1 reserved size load");
    idle(3);
    chk(ld_data === held, "R2 ld_data held after misaligned load", ld_data, held);
    do_req(0, 2'b10, 0, 32'h10, 0, "R2 memory unchanged");

    // back-pressure
    idle(2);
    mem_ready = 0;
    fork begin repeat (3) @(posedge clk); mem_ready <= 1; end join_none
    do_req(1, 2'b00, 0, 32'h20, 32'h0000_0042, "R8 stalled store");
    do_req(0, 2'b00, 0, 32'h20, 0, "R8 load after stall");

    // response and error pulse in the same cycle
    big_endian = 0;
    do_req(0, 2'b10, 0, 32'h18, 0, "R9 load before error");
    do_req(0, 2'b01, 0, 32'h03, 0, "R2 misaligned after load");
    idle(4);
    chk(rsp_q.size() == 0, "R9 all responses seen", rsp_q.size(), 0);
    finish_run();
  end
endmodule